// File: doc/BRIEF.md
# Centre-Aligned Multi-Channel PWM Timer with Commit Lock

This block generates centre-aligned pulse-width signals for a three-phase motor bridge, one output per channel. A single up/down counter runs from zero to a reload value and back, and every channel compares its own compare value against that shared count. Each channel can be set to high-side sense, which inverts the comparison, or low-side sense. Each channel can also be set to active-low drive. Together these settings give complementary pairs around one compare value.

Software loads the prescaler, the reload value and the compare values through a simple write port. These values go into shadow registers. They move into the active set only when the counter turns around, at the top or at the bottom. An option restricts the transfer to the bottom only. While the lock input is high, no transfer takes place at all, so software can rewrite every channel and have all the new values take effect on the same turnaround.

The timer can also run as a gated follower. In that mode the count advances only while the gate input is high, so two timers with equal settings that share the same gate keep identical counts. While the timer is stopped, shadow values transfer at once, and all outputs sit at their inactive level.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the count is 0, the direction is up, and every output is low. The timer stays stopped until bit 0 of the control word (address 0) is written as 1.
- R2: While running, the count steps once per tick. It starts at 0, rises to the active reload value, then falls back to 0, giving a period of twice the reload value in ticks. The direction flag `cnt_up` is high on the rising half.
- R3: A tick occurs every (prescaler + 1) clock cycles. The prescaler is written at address 1.
- R4: In normal sense (mode bit 0), a channel is active while count < compare. A compare of 0 is never active, and a compare above the reload value is always active. Over one period of reload value A, a compare c with 1 ≤ c ≤ A is active for 2c−1 ticks.
- R5: Mode bit i (address 3) set to 1 selects high-side sense for channel i, which inverts the comparison. Polarity bit i (address 4) set to 1 inverts the channel's final output.
- R6: While running, a write to the compare register of channel i (address 8+i) does not change the output until the next turnaround, which is either the count reaching the top or the count reaching 0.
- R7: When control bit 1 is set, shadow values transfer only at the bottom turnaround; a top turnaround leaves the old values in force.
- R8: While `lock` is high, no shadow value transfers. After release, every pending value on every channel takes effect on the same next permitted turnaround.
- R9: A reload write (address 2) while running takes effect at a turnaround. The current peak completes with the old value, and the next peak uses the new one.
- R10: With control bit 2 set, the count and the prescaler hold while `gate_in` is low, and resume stepping when it goes high.
- R11: While control bit 0 is 0, every output sits at its inactive level (equal to its polarity bit), the count returns to 0, and unlocked shadow values transfer on the next cycle.
- R12: A reload write of 0 is stored as 1, so the count alternates between 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Write data |
| lock | input | 1 | Holds off all shadow-to-active transfers while high |
| gate_in | input | 1 | Run gate from a master timer, used when gated mode is on |
| pwm_out | output | NCH | Channel outputs |
| cnt_out | output | CW | Current count |
| cnt_up | output | 1 | High while counting up |

## Verification
On every cycle, the checker confirms the following:
- the count moves by at most one step while running and holds when the gate is closed;
- the reload value is never zero;
- outputs are at their inactive level while the timer is stopped;
- active compare values are frozen under lock, and they change only on the cycle the count turns around (or only at the bottom when that option is on).

Only the bench scenarios can show the rest:
- the exact triangle shape and the period under a prescaler;
- the active-tick count for every compare value across all four sense and polarity combinations;
- that pending values on two channels land together after the lock is released;
- that a new reload value first shows up at the following peak.

// File: rtl/cpwm_pkg.sv
// Shared constants for the centre-aligned PWM timer: register addresses
// and control-word bit positions. Assumes at most eight channels.
package cpwm_pkg;
    localparam int unsigned ADDR_W    = 4;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_PSC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_ARR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd3;
    localparam logic [ADDR_W-1:0] A_POL  = 4'd4;
    localparam int unsigned CMP_BASE  = 8;
    localparam int unsigned MAX_CH    = 8;
    localparam int unsigned CB_RUN    = 0;
    localparam int unsigned CB_BOTTOM = 1;
    localparam int unsigned CB_GATE   = 2;
endpackage

// File: rtl/cpwm_regs.sv
// Register file with shadow/active pairs for prescaler, reload and compare.
// Control, mode and polarity take effect at once. Shadow values move to the
// active set when the timer is stopped, or at a permitted turnaround, and
// never while lock is high. Assumes NCH <= MAX_CH and NCH <= CW.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter int unsigned CW      = 16,
    parameter int unsigned PW      = 8,
    parameter int unsigned ARR_RST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic              lock,
    input  logic              evt_top,
    input  logic              evt_bot,
    output logic              ctrl_run,
    output logic              ctrl_bottom,
    output logic              ctrl_gate,
    output logic [NCH-1:0]    mode_hi,
    output logic [NCH-1:0]    pol_lo,
    output logic [PW-1:0]     psc_act,
    output logic [CW-1:0]     arr_act,
    output logic [NCH*CW-1:0] cmp_flat
);
    logic          commit;
    logic [PW-1:0] psc_sh;
    logic [CW-1:0] arr_sh;
    logic [CW-1:0] cmp_sh  [NCH];
    logic [CW-1:0] cmp_act [NCH];

    // Transfer permission: stopped, or a turnaround allowed by the option, and not locked.
    assign commit = !lock && (!ctrl_run || evt_bot || (evt_top && !ctrl_bottom));

    // Immediate control, mode and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_run    <= 1'b0;
            ctrl_bottom <= 1'b0;
            ctrl_gate   <= 1'b0;
            mode_hi     <= '0;
            pol_lo      <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                ctrl_run    <= wr_data[CB_RUN];
                ctrl_bottom <= wr_data[CB_BOTTOM];
                ctrl_gate   <= wr_data[CB_GATE];
            end
            if (wr_addr == A_MODE) mode_hi <= wr_data[NCH-1:0];
            if (wr_addr == A_POL)  pol_lo  <= wr_data[NCH-1:0];
        end
    end

    // Period shadows (reload clamped to at least 1) and their active copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_sh  <= '0;
            psc_act <= '0;
            arr_sh  <= CW'(ARR_RST);
            arr_act <= CW'(ARR_RST);
        end else begin
            if (wr_en && wr_addr == A_PSC) psc_sh <= wr_data[PW-1:0];
            if (wr_en && wr_addr == A_ARR) arr_sh <= (wr_data == '0) ? CW'(1) : wr_data;
            if (commit) begin
                psc_act <= psc_sh;
                arr_act <= arr_sh;
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        // Compare shadow and active pair of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_sh[i]  <= '0;
                cmp_act[i] <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(CMP_BASE + i)) cmp_sh[i] <= wr_data;
                if (commit) cmp_act[i] <= cmp_sh[i];
            end
        end
        assign cmp_flat[i*CW +: CW] = cmp_act[i];
    end
endmodule

// File: rtl/cpwm_counter.sv
// Prescaler and centre-aligned up/down counter. Flags the top and bottom
// turnarounds combinationally in the cycle whose edge lands on them.
// Assumes arr_act >= 1. Clearing run returns the count to 0, counting up.
module cpwm_counter #(
    parameter int unsigned CW = 16,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          gate_mode,
    input  logic          gate_in,
    input  logic [PW-1:0] psc_act,
    input  logic [CW-1:0] arr_act,
    output logic [CW-1:0] cnt,
    output logic          dir_up,
    output logic          evt_top,
    output logic          evt_bot
);
    logic [PW-1:0] pre_cnt;
    logic          advance;
    logic          tick;
    logic          at_top;
    logic          at_bot;

    // Counting allowed: running, and either not gated or gate open.
    assign advance = run && (!gate_mode || gate_in);
    assign tick    = advance && (pre_cnt >= psc_act);
    assign at_top  = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, arr_act};
    assign at_bot  = cnt <= CW'(1);
    assign evt_top = tick && dir_up && at_top;
    assign evt_bot = tick && !dir_up && at_bot;

    // Prescaler divider and triangle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            cnt     <= '0;
            dir_up  <= 1'b1;
        end else if (advance) begin
            if (tick) begin
                pre_cnt <= '0;
                if (dir_up) begin
                    if (at_top) begin
                        cnt    <= arr_act;
                        dir_up <= 1'b0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end else begin
                    if (at_bot) begin
                        cnt    <= '0;
                        dir_up <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            end else begin
                pre_cnt <= pre_cnt + PW'(1);
            end
        end
    end
endmodule

// File: rtl/cpwm_chan.sv
// One output channel: compares the shared count with the channel's active
// compare value, applies sense and polarity, and forces the inactive
// level while the timer is stopped. Purely combinational.
module cpwm_chan #(
    parameter int unsigned CW = 16
) (
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic          mode_hi,
    input  logic          pol_lo,
    output logic          pwm
);
    logic below;

    // Raw comparison, sense selection, run gating, then polarity.
    always_comb begin
        below = cnt < cmp;
        pwm   = pol_lo ^ (run & (mode_hi ^ below));
    end
endmodule

// File: rtl/cpwm_timer.sv
// Top of the centre-aligned PWM timer: register file, shared counter and
// NCH channel comparators. The turnaround flags from the counter drive the
// shadow transfers in the register file on the same clock edge.
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter int unsigned CW      = 16,
    parameter int unsigned PW      = 8,
    parameter int unsigned ARR_RST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic              lock,
    input  logic              gate_in,
    output logic [NCH-1:0]    pwm_out,
    output logic [CW-1:0]     cnt_out,
    output logic              cnt_up
);
    logic              ctrl_run, ctrl_bottom, ctrl_gate;
    logic [NCH-1:0]    mode_hi, pol_lo;
    logic [PW-1:0]     psc_act;
    logic [CW-1:0]     arr_act;
    logic [NCH*CW-1:0] cmp_flat;
    logic [CW-1:0]     cnt;
    logic              dir_up, evt_top, evt_bot;

    cpwm_regs #(.NCH(NCH), .CW(CW), .PW(PW), .ARR_RST(ARR_RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock(lock), .evt_top(evt_top), .evt_bot(evt_bot),
        .ctrl_run(ctrl_run), .ctrl_bottom(ctrl_bottom), .ctrl_gate(ctrl_gate),
        .mode_hi(mode_hi), .pol_lo(pol_lo), .psc_act(psc_act),
        .arr_act(arr_act), .cmp_flat(cmp_flat)
    );

    cpwm_counter #(.CW(CW), .PW(PW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl_run), .gate_mode(ctrl_gate),
        .gate_in(gate_in), .psc_act(psc_act), .arr_act(arr_act),
        .cnt(cnt), .dir_up(dir_up), .evt_top(evt_top), .evt_bot(evt_bot)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cpwm_chan #(.CW(CW)) ch_i (
            .run(ctrl_run), .cnt(cnt), .cmp(cmp_flat[i*CW +: CW]),
            .mode_hi(mode_hi[i]), .pol_lo(pol_lo[i]), .pwm(pwm_out[i])
        );
    end

    assign cnt_out = cnt;
    assign cnt_up  = dir_up;
endmodule

// File: rtl/cpwm_timer_chk.sv
// Assertion checker for cpwm_timer, bound to its internal state. It checks
// stepping, gating, stop behaviour, lock freeze and turnaround-only transfers.
module cpwm_timer_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16,
    parameter int unsigned PW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic              gate_in,
    input logic              ctrl_run,
    input logic              ctrl_bottom,
    input logic              ctrl_gate,
    input logic [CW-1:0]     cnt,
    input logic              dir_up,
    input logic [CW-1:0]     arr_act,
    input logic [PW-1:0]     psc_act,
    input logic [NCH*CW-1:0] cmp_flat,
    input logic [NCH-1:0]    pol_lo,
    input logic [NCH-1:0]    pwm_out
);
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run && $past(ctrl_run)) |->
            (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) || cnt == $past(cnt) - CW'(1)));

    a_r12_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        arr_act != '0);

    a_r11_stopped_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_run |-> pwm_out == pol_lo);

    a_r10_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run && ctrl_gate && !gate_in) |=> $stable(cnt));

    a_r8_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(cmp_flat) && $stable(arr_act) && $stable(psc_act)));

    a_r6_change_at_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run && $past(ctrl_run) && !$stable(cmp_flat)) |->
            ((cnt == '0 && dir_up) || (!dir_up && $past(dir_up))));

    a_r7_bottom_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run && $past(ctrl_run) && $past(ctrl_bottom) && !$stable(cmp_flat)) |->
            (cnt == '0 && dir_up));
endmodule

bind cpwm_timer cpwm_timer_chk #(.NCH(NCH), .CW(CW), .PW(PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .lock(lock), .gate_in(gate_in),
    .ctrl_run(ctrl_run), .ctrl_bottom(ctrl_bottom), .ctrl_gate(ctrl_gate),
    .cnt(cnt), .dir_up(dir_up), .arr_act(arr_act), .psc_act(psc_act),
    .cmp_flat(cmp_flat), .pol_lo(pol_lo), .pwm_out(pwm_out)
);

// File: tb/cpwm_timer_tb.sv
// Self-checking bench: sweeps every compare value over all sense/polarity
// combinations and runs directed scenarios for shadowing, lock, gate and reload.
module cpwm_timer_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int A   = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic           lock = 1'b0;
    logic           gate_in = 1'b0;
    logic [NCH-1:0] pwm_out;
    logic [CW-1:0]  cnt_out;
    logic           cnt_up;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpwm_timer #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock(lock), .gate_in(gate_in),
        .pwm_out(pwm_out), .cnt_out(cnt_out), .cnt_up(cnt_up)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [3:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int tri_val(input int t, input int arr);
        int p;
        p = t % (2 * arr);
        return (p <= arr) ? p : 2 * arr - p;
    endfunction

    function automatic int on_ticks(input int c, input int arr);
        if (c == 0) return 0;
        if (c <= arr) return 2 * c - 1;
        return 2 * arr;
    endfunction

    task automatic wait_for(input int v, input bit up);
        while (!(int'(cnt_out) == v && cnt_up == up)) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi [NCH];
        int base, peak;
        bit prev_up;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cnt_out == 0, "R1 count", int'(cnt_out), 0);
        chk(cnt_up == 1'b1, "R1 dir", int'(cnt_up), 1);
        chk(pwm_out == '0, "R1 outputs", int'(pwm_out), 0);
        repeat (4) @(negedge clk);
        chk(cnt_out == 0, "R1 stays stopped", int'(cnt_out), 0);

        // R4 R5 R2: full compare sweep over all sense/polarity combinations
        wr(4'd2, A);
        wr(4'd3, 4'b1010);
        wr(4'd4, 4'b1100);
        for (int c = 0; c <= A + 1; c++) begin
            wr(4'd0, 0);
            chk(pwm_out == 4'b1100, "R11 inactive level", int'(pwm_out), 12);
            @(negedge clk);
            chk(cnt_out == 0, "R11 count cleared", int'(cnt_out), 0);
            for (int i = 0; i < NCH; i++) wr(4'(8 + i), c);
            wr(4'd0, 1);
            for (int i = 0; i < NCH; i++) hi[i] = 0;
            for (int k = 0; k < 2 * A; k++) begin
                chk(int'(cnt_out) == tri_val(k, A), "R2 triangle", int'(cnt_out), tri_val(k, A));
                for (int i = 0; i < NCH; i++) hi[i] += int'(pwm_out[i]);
                @(negedge clk);
            end
            base = on_ticks(c, A);
            chk(hi[0] == base, "R4 normal sense", hi[0], base);
            chk(hi[1] == 2 * A - base, "R5 high-side sense", hi[1], 2 * A - base);
            chk(hi[2] == 2 * A - base, "R5 active-low", hi[2], 2 * A - base);
            chk(hi[3] == base, "R5 high-side active-low", hi[3], base);
        end

        // R3: prescaler divides the tick rate
        wr(4'd0, 0);
        wr(4'd1, 2);
        wr(4'd2, 4);
        wr(4'd0, 1);
        for (int k = 0; k < 24; k++) begin
            chk(int'(cnt_out) == tri_val(k / 3, 4), "R3 prescaled count", int'(cnt_out), tri_val(k / 3, 4));
            @(negedge clk);
        end

        // R12: zero reload clamps to one
        wr(4'd0, 0);
        wr(4'd1, 0);
        wr(4'd2, 0);
        wr(4'd0, 1);
        for (int k = 0; k < 6; k++) begin
            chk(int'(cnt_out) == (k % 2), "R12 reload clamp", int'(cnt_out), k % 2);
            @(negedge clk);
        end

        // R6: compare write while running waits for a turnaround
        wr(4'd0, 0);
        wr(4'd2, A);
        wr(4'd3, 0);
        wr(4'd4, 0);
        for (int i = 0; i < NCH; i++) wr(4'(8 + i), 3);
        wr(4'd0, 1);
        wait_for(2, 1'b1);
        wr(4'd8, 5);
        chk(cnt_out == 3 && pwm_out[0] == 1'b0, "R6 no immediate effect", int'(pwm_out[0]), 0);
        wait_for(4, 1'b0);
        chk(pwm_out[0] == 1'b1, "R6 new value after top", int'(pwm_out[0]), 1);

        // R7: bottom-only transfer
        wr(4'd0, 3);
        wait_for(2, 1'b1);
        wr(4'd8, 2);
        wait_for(4, 1'b0);
        chk(pwm_out[0] == 1'b1, "R7 top ignored", int'(pwm_out[0]), 1);
        wait_for(4, 1'b1);
        chk(pwm_out[0] == 1'b0, "R7 taken at bottom", int'(pwm_out[0]), 0);

        // R9: reload change lands at the turnaround; current peak unchanged
        wr(4'd0, 1);
        wait_for(2, 1'b1);
        wr(4'd2, 4);
        while (cnt_up) @(negedge clk);
        peak = int'(cnt_out);
        chk(peak == A, "R9 current peak", peak, A);
        while (!cnt_up) @(negedge clk);
        while (cnt_up) @(negedge clk);
        peak = int'(cnt_out);
        chk(peak == 4, "R9 next peak", peak, 4);
        wr(4'd2, A);
        while (!cnt_up) @(negedge clk);
        while (cnt_up) @(negedge clk);

        // R8: lock holds two channels, release commits them together
        wait_for(1, 1'b1);
        lock = 1'b1;
        wr(4'd8, 5);
        wr(4'd9, 5);
        for (int k = 0; k < 4 * A; k++) begin
            chk(pwm_out[0] == (cnt_out < 2), "R8 ch0 held", int'(pwm_out[0]), int'(cnt_out < 2));
            chk(pwm_out[1] == (cnt_out < 3), "R8 ch1 held", int'(pwm_out[1]), int'(cnt_out < 3));
            @(negedge clk);
        end
        lock = 1'b0;
        prev_up = cnt_up;
        @(negedge clk);
        while (cnt_up == prev_up) begin
            prev_up = cnt_up;
            chk(pwm_out[0] == (cnt_out < 2), "R8 ch0 before turn", int'(pwm_out[0]), int'(cnt_out < 2));
            @(negedge clk);
        end
        for (int k = 0; k < 2 * A; k++) begin
            chk(pwm_out[0] == (cnt_out < 5), "R8 ch0 committed", int'(pwm_out[0]), int'(cnt_out < 5));
            chk(pwm_out[1] == (cnt_out < 5), "R8 ch1 committed", int'(pwm_out[1]), int'(cnt_out < 5));
            @(negedge clk);
        end

        // R10: gated follower holds and resumes
        gate_in = 1'b0;
        wr(4'd0, 5);
        base = int'(cnt_out);
        repeat (5) @(negedge clk);
        chk(int'(cnt_out) == base, "R10 hold while gate low", int'(cnt_out), base);
        gate_in = 1'b1;
        @(negedge clk);
        chk(int'(cnt_out) != base, "R10 resume on gate high", int'(cnt_out), base + 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule